// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control

This block holds the status and control word for one downstream port of a bus root hub. A read returns port state in the low half-word and latched change flags in the high half-word. A write is a set of one-shot commands, and some bit positions mean something different on write than on read. Writing 1 to position 0 disables the port, while reading position 0 returns the connect state. Writing 1 to position 9 removes power, while reading position 9 returns low-speed attach.

Two inputs from the line monitor feed the block: connect detect and low-speed detect. A built-in sequencer drives port reset signalling for a fixed number of clock cycles, which is 10 ms at 12 MHz by default. A command that would act on a disconnected port is refused, and the block raises the connect-change flag so that software looks at the port again. Writes that arrive while a bus transaction is in flight are held until it ends. A one-cycle pulse tells the interrupt logic each time a change flag becomes set.

Top module: `rh_port_ctl`

## Requirements
- R1: After reset the removable-port read word is all zero, and port_reset, port_power, port_enable and status_change_pulse are all low.
- R2: Read bit 0 follows the connect detect input one cycle later. Read bit 9 is low-speed detect ANDed with bit 0. Read bit 16 (connect change) sets on every connect and every disconnect.
- R3: Writing 1 to bit 1 on a connected port sets port enable, seen at read bit 1 and at port_enable. Writing 1 to bit 0 clears port enable. When both are written in one word, the clear wins.
- R4: Writing 1 to bit 8 turns port power on, seen at read bit 8 and at port_power. Writing 1 to bit 9 turns it off. When both are written in one word, the off command wins.
- R5: Writing 1 to bit 4 on a connected port raises port_reset and read bit 4 for exactly RESET_CYCLES cycles. When they fall, read bit 20 (reset change) sets. A second bit-4 write during the reset does not restart it.
- R6: Writing 1 to bit 4 (reset), bit 1 (enable) or bit 2 (suspend) while the port is disconnected changes neither port_reset nor port_enable, and sets read bit 16 instead.
- R7: Writing 1 to bit 16 or bit 20 clears that change flag. Writing 0 to a change flag leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R8: While xfer_busy is high, written commands take no effect. They are merged by OR and applied in the first cycle that xfer_busy is low.
- R9: A disconnect clears port enable at once and aborts a running reset, without setting bit 20.
- R10: With NON_REMOVABLE set, read bit 0 is always 1. Bit 16 sets once in the first cycle after reset and never from line activity.
- R11: status_change_pulse is high for one cycle in the same cycle that bit 16 or bit 20 first reads 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low root hub reset |
| conn_det | input | 1 | Connect detect from the line monitor, already synchronized |
| lowspd_det | input | 1 | Low-speed device detect from the line monitor |
| xfer_busy | input | 1 | High while a bus transaction is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write command word |
| rd_data | output | 32 | Register read word |
| port_reset | output | 1 | Drives reset signalling on the port |
| port_power | output | 1 | Port power switch control |
| port_enable | output | 1 | Port enable control |
| status_change_pulse | output | 1 | One-cycle pulse when a change flag sets |

## Verification
The assertions assume that conn_det and lowspd_det are already synchronous to clk and change only between edges. They also assume that xfer_busy drops for at least one cycle between transactions, so that held commands are eventually applied. The stimulus changes every input just after a falling edge and holds it across the next rising edge. It ends each busy window explicitly and reads every outcome at a falling edge. The reset length is shortened to 20 cycles, so that a whole reset sequence and its abort case fit in a short run.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int unsigned WORD_W = 32;

  // read-side and write-side bit positions; software decodes these
  localparam int unsigned B_CONN  = 0;   // read: connected   / write: disable
  localparam int unsigned B_ENA   = 1;   // read: enabled     / write: enable
  localparam int unsigned B_SUSP  = 2;   // write: suspend request
  localparam int unsigned B_RST   = 4;   // read: reset active / write: start reset
  localparam int unsigned B_PWR   = 8;   // read: powered     / write: power on
  localparam int unsigned B_LOW   = 9;   // read: low speed   / write: power off
  localparam int unsigned B_CCHG  = 16;  // connect change flag, write 1 clears
  localparam int unsigned B_RCHG  = 20;  // reset done flag, write 1 clears

  typedef struct packed {
    logic dis_port;
    logic ena_port;
    logic susp_req;
    logic rst_req;
    logic pwr_on;
    logic pwr_off;
    logic ack_cchg;
    logic ack_rchg;
  } port_cmd_t;

  function automatic port_cmd_t cmd_decode(input logic [WORD_W-1:0] w);
    port_cmd_t c;
    c.dis_port = w[B_CONN];
    c.ena_port = w[B_ENA];
    c.susp_req = w[B_SUSP];
    c.rst_req  = w[B_RST];
    c.pwr_on   = w[B_PWR];
    c.pwr_off  = w[B_LOW];
    c.ack_cchg = w[B_CCHG];
    c.ack_rchg = w[B_RCHG];
    return c;
  endfunction
endpackage

// File: rtl/rh_cmd_stage.sv
module rh_cmd_stage
  import rh_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              xfer_busy,
  output port_cmd_t         cmd
);
  port_cmd_t hold_q, hold_d, incoming, merged;
  logic      held_q, held_d, hold_ce;

  always_comb begin
    incoming = wr_en ? cmd_decode(wr_data) : '0;
    merged   = hold_q | incoming;
    hold_ce  = xfer_busy ? wr_en : held_q;
    if (xfer_busy) begin
      hold_d = merged;
      held_d = 1'b1;
      cmd    = '0;
    end else begin
      hold_d = '0;
      held_d = 1'b0;
      cmd    = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held_q <= 1'b0;
    end else if (hold_ce) begin
      hold_q <= hold_d;
      held_q <= held_d;
    end
  end

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (cmd == '0));
  p_release_applies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && wr_en && cmd_decode(wr_data).pwr_on) |=> (xfer_busy || cmd.pwr_on));
endmodule

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
  parameter int unsigned RESET_CYCLES = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic done
);
  localparam int unsigned CW   = $clog2(RESET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    done  = act_q && !abort && (cnt_q == LAST);
    act_d = act_q;
    cnt_d = cnt_q;
    if (abort) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      if (done) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !abort && cnt_q != LAST) |=> act_q);
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && start && !abort && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rh_change_flags.sv
module rh_change_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cchg,
  input  logic set_rchg,
  input  logic ack_cchg,
  input  logic ack_rchg,
  output logic cchg,
  output logic rchg,
  output logic pulse
);
  logic cchg_q, cchg_d, rchg_q, rchg_d, pulse_q, pulse_d;

  always_comb begin
    cchg_d  = set_cchg | (cchg_q & ~ack_cchg);
    rchg_d  = set_rchg | (rchg_q & ~ack_rchg);
    pulse_d = (cchg_d & ~cchg_q) | (rchg_d & ~rchg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cchg_q  <= 1'b0;
      rchg_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cchg_q  <= cchg_d;
      rchg_q  <= rchg_d;
      pulse_q <= pulse_d;
    end
  end

  assign cchg  = cchg_q;
  assign rchg  = rchg_q;
  assign pulse = pulse_q;

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cchg && !set_cchg) |=> !cchg_q);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_rchg |=> rchg_q);
  p_pulse_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cchg_q) || $rose(rchg_q)) |-> pulse_q);
  p_pulse_has_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cchg_q || rchg_q));
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
  import rh_port_pkg::*;
#(
  parameter int unsigned RESET_CYCLES  = 120000,
  parameter bit          NON_REMOVABLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conn_det,
  input  logic        lowspd_det,
  input  logic        xfer_busy,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        port_reset,
  output logic        port_power,
  output logic        port_enable,
  output logic        status_change_pulse
);
  port_cmd_t cmd;
  logic conn_q, low_q, boot_q, ena_q, ena_d, pwr_q, pwr_d;
  logic connected, line_evt, unplug, refuse, rst_start, rst_done, rst_active;
  logic set_cchg, cchg, rchg;

  rh_cmd_stage u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_busy(xfer_busy), .cmd(cmd)
  );

  always_comb begin
    connected = NON_REMOVABLE ? 1'b1 : conn_q;
    line_evt  = !NON_REMOVABLE && (conn_det != conn_q);
    unplug    = line_evt && conn_q;
    refuse    = !connected && (cmd.rst_req || cmd.ena_port || cmd.susp_req);
    rst_start = connected && cmd.rst_req;
    set_cchg  = line_evt || refuse || (NON_REMOVABLE && !boot_q);

    ena_d = ena_q;
    if (unplug || cmd.dis_port)        ena_d = 1'b0;
    else if (cmd.ena_port && connected) ena_d = 1'b1;

    pwr_d = pwr_q;
    if (cmd.pwr_off)     pwr_d = 1'b0;
    else if (cmd.pwr_on) pwr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      low_q  <= 1'b0;
      boot_q <= 1'b0;
      ena_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      conn_q <= conn_det;
      low_q  <= lowspd_det;
      boot_q <= 1'b1;
      ena_q  <= ena_d;
      pwr_q  <= pwr_d;
    end
  end

  rh_reset_timer #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .abort(unplug),
    .active(rst_active), .done(rst_done)
  );

  rh_change_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_cchg(set_cchg), .set_rchg(rst_done),
    .ack_cchg(cmd.ack_cchg), .ack_rchg(cmd.ack_rchg),
    .cchg(cchg), .rchg(rchg), .pulse(status_change_pulse)
  );

  always_comb begin
    rd_data         = '0;
    rd_data[B_CONN] = connected;
    rd_data[B_ENA]  = ena_q;
    rd_data[B_RST]  = rst_active;
    rd_data[B_PWR]  = pwr_q;
    rd_data[B_LOW]  = connected && low_q;
    rd_data[B_CCHG] = cchg;
    rd_data[B_RCHG] = rchg;
  end

  assign port_reset  = rst_active;
  assign port_power  = pwr_q;
  assign port_enable = ena_q;

  p_refuse_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (rd_data[B_CCHG] && !port_enable && !$rose(port_reset)));
  p_unplug_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unplug |=> (!port_enable && !port_reset && !$rose(rd_data[B_RCHG])));
  p_end_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(port_reset) && rd_data[B_CONN]) |-> rd_data[B_RCHG]);
  p_power_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pwr_off |=> !port_power);
  p_fixed_conn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (NON_REMOVABLE && boot_q && !rd_data[B_CCHG]) |=> !rd_data[B_CCHG]);
endmodule

// File: tb/rh_port_ctl_tb.sv
module rh_port_ctl_tb;
  localparam int unsigned N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conn_det = 1'b0, lowspd_det = 1'b0, xfer_busy = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd, rd_nr;
  logic prst, ppwr, pena, pulse, prst_nr, ppwr_nr, pena_nr, pulse_nr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rh_port_ctl #(.RESET_CYCLES(N), .NON_REMOVABLE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .conn_det(conn_det), .lowspd_det(lowspd_det),
    .xfer_busy(xfer_busy), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd),
    .port_reset(prst), .port_power(ppwr), .port_enable(pena),
    .status_change_pulse(pulse));

  rh_port_ctl #(.RESET_CYCLES(N), .NON_REMOVABLE(1'b1)) u_dut_nr (
    .clk(clk), .rst_n(rst_n), .conn_det(conn_det), .lowspd_det(lowspd_det),
    .xfer_busy(xfer_busy), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_nr),
    .port_reset(prst_nr), .port_power(ppwr_nr), .port_enable(pena_nr),
    .status_change_pulse(pulse_nr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic prev_c;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd, 32'h0);
    chk("R1 outs", {prst, ppwr, pena, pulse}, 4'b0);
    // R10 non-removable port
    chk("R10 conn", rd_nr[0], 1'b1);
    chk("R10 chg", rd_nr[16], 1'b1);

    // R2 sweep over connect and speed
    prev_c = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); conn_det = i[1]; lowspd_det = i[0];
      @(negedge clk);
      chk("R2 conn", rd[0], i[1]);
      chk("R2 low", rd[9], i[1] & i[0]);
      if (i[1] != prev_c) chk("R2 chg", rd[16], 1'b1);
      prev_c = i[1];
      wr(32'h0001_0000);
      chk("R7 clear", rd[16], 1'b0);
    end
    chk("R10 no line chg", rd_nr[16], 1'b0);

    // R6 refused commands while disconnected
    @(negedge clk); conn_det = 1'b0; lowspd_det = 1'b0;
    @(negedge clk); wr(32'h0001_0000);
    for (int b = 0; b < 3; b++) begin
      wr(32'h1 << ((b == 0) ? 4 : b));
      chk("R6 chg", rd[16], 1'b1);
      chk("R6 no act", {prst, pena}, 2'b00);
      wr(32'h0);
      chk("R7 zero no effect", rd[16], 1'b1);
      wr(32'h0001_0000);
    end

    // connect
    @(negedge clk); conn_det = 1'b1;
    @(negedge clk);
    chk("R11 pulse", pulse, 1'b1);
    @(negedge clk);
    chk("R11 single", pulse, 1'b0);
    wr(32'h0001_0000);

    // R4 power
    wr(32'h100);  chk("R4 on", {rd[8], ppwr}, 2'b11);
    wr(32'h200);  chk("R4 off", {rd[8], ppwr}, 2'b00);
    wr(32'h300);  chk("R4 off wins", ppwr, 1'b0);

    // R3 enable
    wr(32'h2);    chk("R3 set", {rd[1], pena}, 2'b11);
    wr(32'h0);    chk("R3 zero", pena, 1'b1);
    wr(32'h1);    chk("R3 clr", {rd[1], pena}, 2'b00);
    wr(32'h3);    chk("R3 clr wins", pena, 1'b0);
    chk("R2 conn kept", rd[0], 1'b1);

    // R5 timed reset
    wr(32'h10);
    len = 0;
    while (prst && len < 100) begin
      if (len == 5) begin
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h10; len++;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
      end else @(negedge clk);
      len++;
    end
    chk("R5 length", len, N);
    chk("R5 done flag", {rd[4], rd[20]}, 2'b01);
    chk("R11 pulse rst", pulse, 1'b1);
    wr(32'h0);    chk("R7 keep", rd[20], 1'b1);
    wr(32'h0010_0000); chk("R7 clr rst flag", rd[20], 1'b0);

    // R8 deferral
    @(negedge clk); xfer_busy = 1'b1;
    wr(32'h2);
    wr(32'h100);
    repeat (3) @(negedge clk);
    chk("R8 held", {pena, ppwr}, 2'b00);
    xfer_busy = 1'b0;
    @(negedge clk);
    chk("R8 applied", {pena, ppwr}, 2'b11);

    // R9 disconnect during reset
    wr(32'h10);
    repeat (4) @(negedge clk);
    chk("R9 running", prst, 1'b1);
    conn_det = 1'b0;
    @(negedge clk);
    chk("R9 abort", {prst, pena, rd[16]}, 3'b001);
    repeat (N + 4) @(negedge clk);
    chk("R9 no done", rd[20], 1'b0);
    chk("R10 steady", {rd_nr[0], rd_nr[16]}, 2'b10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule